// File: doc/BRIEF.md
# Serial Port Interrupt Pending and Mask Controller

This block keeps the interrupt state of one serial port channel and drives a single level-sensitive interrupt line towards the system interrupt controller. The receive path, transmit path and modem-status logic each deliver single-cycle event pulses. A source register latches them, a mask register hides selected sources, and a derived pending register shows which unmasked sources are active. Software reaches all three through a small register port. Writing ones to either the pending or the source register clears the bits at those positions.

When the channel's FIFOs are enabled, the block also raises the transmit source by itself. It does so for as long as the transmit FIFO occupancy is at or below a threshold. That threshold is a 3-bit trigger code times a multiplier fixed by the channel number, which is set when the block is built. The serial shifters, the FIFOs and the baud generator stay outside; this block only sees their event pulses, the FIFO enable, the trigger code and the occupancy count.

Top module: `uirq_ctrl`

## Requirements
- R1: Source bit positions are fixed: bit 0 receive, bit 1 error, bit 2 transmit, bit 3 modem. An event pulse on an input sets its source bit in the register at the next rising clock edge, and the bit stays set until software clears it.
- R2: Register select encoding: 0 reads pending, 1 reads source, 2 reads mask, 3 reads zero. Pending always equals source AND NOT mask.
- R3: After reset, `irq_o` is high exactly when the current pending value is non-zero.
- R4: A write with select 0 clears every source bit where the written data is one, so the same bits drop out of pending.
- R5: A write with select 1 clears the source bits where the written data is one and leaves the mask unchanged.
- R6: A write with select 2 loads the mask. From the next edge, both pending and `irq_o` reflect the new mask.
- R7: If an event for a bit (an input pulse or the FIFO transmit condition) arrives in the same cycle as a software clear of that bit, the bit stays set.
- R8: While `fifo_en` is high, the transmit source bit is set at the next edge whenever `tx_count` is less than or equal to `tx_trig` times the channel multiplier. The multiplier is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 (threshold 0) for any other channel.
- R9: While `fifo_en` is low, `tx_count` and `tx_trig` have no effect on any source bit.
- R10: Reset clears the source, mask and pending registers and holds `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_rx | input | 1 | Receive event pulse |
| ev_err | input | 1 | Receive error event pulse |
| ev_tx | input | 1 | Transmit done event pulse |
| ev_modem | input | 1 | Modem status event pulse |
| fifo_en | input | 1 | FIFO mode enable |
| tx_trig | input | 3 | Transmit trigger code |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 pending, 1 source, 2 mask) |
| wr_data | input | 4 | Write data, one bit per source |
| rd_data | output | 4 | Read data for the selected register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block for channel 2 with a 5-bit occupancy count. With a multiplier of 2, every trigger code gives a threshold between 0 and 14, so random occupancy values fall on both sides of the threshold, and land exactly on it, often. Directed steps cover the threshold edge (count equal to the threshold and one above it), a zero trigger code with an empty FIFO, and clears that collide with events. The multipliers of the other channels come from the same elaborated expression and are not reached by this build.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NSRC   = 4;
    localparam int SRC_RX = 0;
    localparam int SRC_ER = 1;
    localparam int SRC_TX = 2;
    localparam int SRC_MD = 3;
    localparam int TRIG_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_PEND = 2'd0,
        SEL_SRC  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_RSVD = 2'd3
    } sel_e;

    typedef struct packed {
        logic [NSRC-1:0] src;
        logic [NSRC-1:0] mask;
        logic            irq;
    } irq_state_t;

    function automatic int trig_mult(input int ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/uirq_txlvl.sv
module uirq_txlvl
    import uirq_pkg::*;
#(
    parameter int CHANNEL = 0,
    parameter int CNT_W   = 8
) (
    input  logic              fifo_en,
    input  logic [TRIG_W-1:0] tx_trig,
    input  logic [CNT_W-1:0]  tx_count,
    output logic              tx_hit
);
    localparam int MULT  = trig_mult(CHANNEL);
    localparam int LVL_W = TRIG_W + 6;
    localparam int CMP_W = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1;

    logic [CMP_W-1:0] level;
    logic [CMP_W-1:0] count_x;

    generate
        if (MULT == 0) begin : g_zero
            assign level = '0;
        end else begin : g_scaled
            assign level = CMP_W'(tx_trig) * CMP_W'(MULT);
        end
    endgenerate

    assign count_x = CMP_W'(tx_count);
    assign tx_hit  = fifo_en && (count_x <= level);
endmodule

// File: rtl/uirq_wdec.sv
module uirq_wdec
    import uirq_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [NSRC-1:0]  wr_data,
    output logic [NSRC-1:0]  clr_src,
    output logic             mask_we
);
    always_comb begin
        clr_src = '0;
        mask_we = 1'b0;
        if (wr_en) begin
            case (sel_e'(reg_sel))
                SEL_PEND, SEL_SRC: clr_src = wr_data;
                SEL_MASK:          mask_we = 1'b1;
                default:           ;
            endcase
        end
    end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int CHANNEL = 0,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_rx,
    input  logic             ev_err,
    input  logic             ev_tx,
    input  logic             ev_modem,
    input  logic             fifo_en,
    input  logic [2:0]       tx_trig,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             wr_en,
    input  logic [1:0]       reg_sel,
    input  logic [3:0]       wr_data,
    output logic [3:0]       rd_data,
    output logic             irq_o
);
    irq_state_t      st_q, st_d;
    logic [NSRC-1:0] ev_vec;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_src;
    logic [NSRC-1:0] pend;
    logic            mask_we;
    logic            tx_hit;

    uirq_txlvl #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_txlvl (
        .fifo_en  (fifo_en),
        .tx_trig  (tx_trig),
        .tx_count (tx_count),
        .tx_hit   (tx_hit)
    );

    uirq_wdec u_wdec (
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .clr_src (clr_src),
        .mask_we (mask_we)
    );

    always_comb begin
        ev_vec         = '0;
        ev_vec[SRC_RX] = ev_rx;
        ev_vec[SRC_ER] = ev_err;
        ev_vec[SRC_TX] = ev_tx;
        ev_vec[SRC_MD] = ev_modem;
        set_vec         = ev_vec;
        set_vec[SRC_TX] = ev_tx | tx_hit;
    end

    always_comb begin
        st_d     = st_q;
        st_d.src = (st_q.src & ~clr_src) | set_vec;
        if (mask_we) begin
            st_d.mask = wr_data;
        end
        st_d.irq = |(st_d.src & ~st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend  = st_q.src & ~st_q.mask;
    assign irq_o = st_q.irq;

    always_comb begin
        case (sel_e'(reg_sel))
            SEL_PEND: rd_data = pend;
            SEL_SRC:  rd_data = st_q.src;
            SEL_MASK: rd_data = st_q.mask;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_rx,
    input logic       ev_err,
    input logic       ev_modem,
    input logic       wr_en,
    input logic [1:0] reg_sel,
    input logic [3:0] wr_data,
    input logic       irq_o,
    input logic [3:0] src_q,
    input logic [3:0] mask_q,
    input logic       tx_hit
);
    // R1
    rx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx |=> src_q[0]);

    // R1
    modem_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_modem |=> src_q[3]);

    // R3
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(src_q & ~mask_q)));

    // R5
    src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd1 && wr_data[1] && !ev_err) |=> !src_q[1]);

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd2) |=> (mask_q == $past(wr_data)));

    // R7
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel[1] && wr_data[0] && ev_rx) |=> src_q[0]);

    // R8
    tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hit |=> src_q[2]);
endmodule

bind uirq_ctrl uirq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_rx    (ev_rx),
    .ev_err   (ev_err),
    .ev_modem (ev_modem),
    .wr_en    (wr_en),
    .reg_sel  (reg_sel),
    .wr_data  (wr_data),
    .irq_o    (irq_o),
    .src_q    (st_q.src),
    .mask_q   (st_q.mask),
    .tx_hit   (tx_hit)
);

// File: tb/uirq_ctrl_tb.sv
`timescale 1ns/1ps
module uirq_ctrl_tb;
    localparam int CH    = 2;
    localparam int CNT_W = 5;
    localparam int MULT  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ev_rx = 0, ev_err = 0, ev_tx = 0, ev_modem = 0;
    logic             fifo_en = 0;
    logic [2:0]       tx_trig = 0;
    logic [CNT_W-1:0] tx_count = 0;
    logic             wr_en = 0;
    logic [1:0]       reg_sel = 0;
    logic [3:0]       wr_data = 0;
    logic [3:0]       rd_data;
    logic             irq_o;

    int total = 0;
    int fails = 0;
    logic [3:0] m_src = 0, m_mask = 0;
    logic       m_irq = 0;
    logic [3:0] last_rd;
    logic       last_irq;

    always #4 clk = ~clk;

    uirq_ctrl #(.CHANNEL(CH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_err(ev_err),
        .ev_tx(ev_tx), .ev_modem(ev_modem), .fifo_en(fifo_en),
        .tx_trig(tx_trig), .tx_count(tx_count), .wr_en(wr_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model_rd(input logic [1:0] sel);
        case (sel)
            2'd0:    return m_src & ~m_mask;
            2'd1:    return m_src;
            2'd2:    return m_mask;
            default: return 4'h0;
        endcase
    endfunction

    // Drive one cycle at the falling edge, check the pre-edge state, advance the model.
    task automatic step(input logic [3:0] ev, input logic we, input logic [1:0] sel,
                        input logic [3:0] wd, input logic fen, input logic [2:0] trig,
                        input logic [CNT_W-1:0] cnt, input string tag);
        logic       hit;
        logic [3:0] clr;
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = ev;
        wr_en = we; reg_sel = sel; wr_data = wd;
        fifo_en = fen; tx_trig = trig; tx_count = cnt;
        #1;
        last_rd  = rd_data;
        last_irq = irq_o;
        chk(tag, rd_data, model_rd(sel));
        chk("R3", {3'b0, irq_o}, {3'b0, m_irq});
        hit = fen && (int'(cnt) <= int'(trig) * MULT);
        clr = (we && !sel[1]) ? wd : 4'h0;
        m_src = (m_src & ~clr) | ev | {1'b0, hit, 2'b0};
        if (we && sel == 2'd2) m_mask = wd;
        m_irq = |(m_src & ~m_mask);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #1_000_000;
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R10: reset state across all selects
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            reg_sel = 2'(s);
            #1;
            chk("R10", rd_data, 4'h0);
            chk("R10", {3'b0, irq_o}, 4'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: events set bits
        step(4'b0001, 0, 2'd1, 0, 0, 0, 0, "R1");
        step(4'b1010, 0, 2'd1, 0, 0, 0, 0, "R1");
        chk("R1", last_rd, 4'b0001);
        step(4'b0000, 0, 2'd1, 0, 0, 0, 0, "R1");
        chk("R1", last_rd, 4'b1011);
        // R6, R2: mask and pending views
        step(4'b0000, 1, 2'd2, 4'b0011, 0, 0, 0, "R6");
        step(4'b0000, 0, 2'd0, 0, 0, 0, 0, "R2");
        chk("R2", last_rd, 4'b1000);
        chk("R3", {3'b0, last_irq}, 4'h1);
        step(4'b0000, 0, 2'd3, 0, 0, 0, 0, "R2");
        chk("R2", last_rd, 4'h0);
        // R4: clear through pending select
        step(4'b0000, 1, 2'd0, 4'b1000, 0, 0, 0, "R4");
        step(4'b0000, 0, 2'd1, 0, 0, 0, 0, "R4");
        chk("R4", last_rd, 4'b0011);
        chk("R4", {3'b0, last_irq}, 4'h0);
        // R5: clear through source select, mask unchanged
        step(4'b0000, 1, 2'd1, 4'b0001, 0, 0, 0, "R5");
        step(4'b0000, 0, 2'd1, 0, 0, 0, 0, "R5");
        chk("R5", last_rd, 4'b0010);
        step(4'b0000, 0, 2'd2, 0, 0, 0, 0, "R5");
        chk("R5", last_rd, 4'b0011);
        // R6: unmask raises irq on the next edge
        step(4'b0000, 1, 2'd2, 4'b0000, 0, 0, 0, "R6");
        step(4'b0000, 0, 2'd0, 0, 0, 0, 0, "R6");
        chk("R6", {3'b0, last_irq}, 4'h1);
        // R7: event collides with clear
        step(4'b0010, 1, 2'd1, 4'b0010, 0, 0, 0, "R7");
        step(4'b0000, 0, 2'd1, 0, 0, 0, 0, "R7");
        chk("R7", last_rd, 4'b0010);
        // R8: threshold 6 with trigger 3
        step(4'b0000, 1, 2'd1, 4'b1111, 1, 3'd3, 5'd7, "R8");
        step(4'b0000, 0, 2'd1, 0, 1, 3'd3, 5'd7, "R8");
        chk("R8", last_rd, 4'h0);
        step(4'b0000, 0, 2'd1, 0, 1, 3'd3, 5'd6, "R8");
        chk("R8", last_rd, 4'h0);
        step(4'b0000, 0, 2'd1, 0, 0, 3'd3, 5'd6, "R8");
        chk("R8", last_rd, 4'b0100);
        step(4'b0000, 1, 2'd1, 4'b1111, 1, 3'd0, 5'd0, "R8");
        step(4'b0000, 0, 2'd1, 0, 0, 0, 0, "R8");
        chk("R8", last_rd, 4'b0100);
        // R9: FIFO mode off, empty FIFO does nothing
        step(4'b0000, 1, 2'd1, 4'b1111, 0, 3'd7, 5'd0, "R9");
        step(4'b0000, 0, 2'd1, 0, 0, 3'd7, 5'd0, "R9");
        step(4'b0000, 0, 2'd1, 0, 0, 0, 0, "R9");
        chk("R9", last_rd, 4'h0);

        // Random phase
        void'($urandom(32'd5150));
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] ev;
            ev = 4'($urandom) & 4'($urandom) & 4'($urandom);
            step(ev, ($urandom % 3) == 0, 2'($urandom), 4'($urandom),
                 1'($urandom), 3'($urandom), 5'($urandom), "R2");
        end

        summary();
        $finish;
    end
endmodule